// File: doc/BRIEF.md
# Partitioned m-out-of-n concurrent checker

This block watches the coded outputs and the coded present state of a self-checking finite-state machine on every cycle. The machine's outputs arrive already split into fixed groups. Each of two small groups carries its functional bits plus one check bit and must form a 1-out-of-(k+1) word. The leftover single-bit outputs are gathered into one merged group, which must hold exactly m ones out of n. The state vector is a separate m-out-of-n word. A word is treated as a codeword only when its count of ones equals its m. Any other count is an error, so any set of bit flips that all go the same way is caught.

Each of the four verdicts is a two-rail pair. The pairs are merged two at a time by 2-out-of-4 stages into one two-rail indication. A registered flag records the first non-code indication seen while checking is enabled. The flag stays set until a synchronous clear. All widths and code weights are elaboration parameters, and the input width is derived from them.

Top module: `mofn_part_checker`

## Requirements
- R1: Group A occupies `word_i[K0:0]`, and its verdict is valid exactly when it holds one 1. A word with zero ones or with two or more ones makes `err_rail` 00.
- R2: Group B occupies the next K1+1 bits above group A, and its verdict is valid exactly when it holds one 1.
- R3: The merged group occupies the next MN bits, and its verdict is valid exactly when its count of ones equals MM. The default is 2-out-of-4.
- R4: The state word occupies the top SN bits, and its verdict is valid exactly when its count of ones equals SM. The default is 3-out-of-6.
- R5: `err_rail` is combinational from `word_i`. It is 01 when all four verdicts are valid and 00 when any one or more is invalid, including several invalid groups at the same time. The codes 01 and 10 mean valid; 00 and 11 mean error.
- R6: `err_flag` becomes 1 at the clock edge after a cycle in which `chk_en` is 1, `clr` is 0 and `err_rail` is not 01 or 10. It does not become 1 on a non-code indication while `chk_en` is 0.
- R7: Once set, `err_flag` stays 1 until a cycle with `clr` high. It is 0 after that edge, and `clr` takes priority over a set in the same cycle.
- R8: While `rst_n` is low, `err_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Allows a non-code indication to set the flag |
| clr | input | 1 | Synchronous clear of the flag |
| word_i | input | K0+K1+MN+SN+2 | Packed groups: A lowest, then B, merged group, state highest |
| err_rail | output | 2 | Combined two-rail verdict (01 = valid, 00 = error) |
| err_flag | output | 1 | Sticky registered error flag |

## Verification
A miscounted group or a wrong stage output shows at `err_rail` in the same cycle as the faulty word. For that reason, each field is swept over all of its values while the others are held valid, and mixed words with several bad fields are applied as well. A flag register that sets wrongly, fails to hold or ignores the clear shows on `err_flag` one edge later. It is sampled at the following falling edge.

// File: rtl/mofn_part_checker.sv
module mofn_part_checker #(
  parameter int K0 = 4,
  parameter int K1 = 3,
  parameter int MN = 4,
  parameter int MM = 2,
  parameter int SN = 6,
  parameter int SM = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_en,
  input  logic                        clr,
  input  logic [K0+K1+MN+SN+1:0]      word_i,
  output logic [1:0]                  err_rail,
  output logic                        err_flag
);
  localparam int W0 = K0 + 1;
  localparam int W1 = K1 + 1;
  localparam int OB = W0;
  localparam int OM = W0 + W1;
  localparam int OS = OM + MN;

  function automatic logic [1:0] verdict(input int cnt, input int m);
    return (cnt == m) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [1:0] stage24(input logic [1:0] a, input logic [1:0] b);
    return ($countones({a, b}) == 2) ? 2'b01 : 2'b00;
  endfunction

  logic [1:0] v_a, v_b, v_m, v_s, lo_pair, hi_pair;

  assign v_a = verdict($countones(word_i[W0-1:0]), 1);
  assign v_b = verdict($countones(word_i[OB +: W1]), 1);
  assign v_m = verdict($countones(word_i[OM +: MN]), MM);
  assign v_s = verdict($countones(word_i[OS +: SN]), SM);

  assign lo_pair  = stage24(v_a, v_b);
  assign hi_pair  = stage24(v_m, v_s);
  assign err_rail = stage24(lo_pair, hi_pair);

  wire noncode = (err_rail[0] == err_rail[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                err_flag <= 1'b0;
    else if (clr)              err_flag <= 1'b0;
    else if (chk_en && noncode) err_flag <= 1'b1;
  end

  a_r6_sets_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !clr && err_rail != 2'b01 && err_rail != 2'b10) |=> err_flag);

  a_r6_no_set_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !chk_en) |=> !err_flag);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_flag);

  always_comb begin
    a_r5_rail_legal: assert (err_rail != 2'b10 && err_rail != 2'b11);
  end
endmodule

// File: tb/mofn_part_checker_test.sv
module mofn_part_checker_test;
  logic clk = 1'b0, rst_n = 1'b0, chk_en = 1'b0, clr = 1'b0;
  logic [18:0] word_i = '0;
  logic [1:0] err_rail;
  logic err_flag;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mofn_part_checker uut (.clk(clk), .rst_n(rst_n), .chk_en(chk_en), .clr(clr),
                         .word_i(word_i), .err_rail(err_rail), .err_flag(err_flag));

  localparam logic [4:0] GA_OK = 5'b00100;
  localparam logic [3:0] GB_OK = 4'b0010;
  localparam logic [3:0] GM_OK = 4'b0101;
  localparam logic [5:0] ST_OK = 6'b100110;

  function automatic logic [1:0] expect_rail(input logic [18:0] w);
    bit ok;
    ok = ($countones(w[4:0]) == 1) && ($countones(w[8:5]) == 1) &&
         ($countones(w[12:9]) == 2) && ($countones(w[18:13]) == 3);
    return ok ? 2'b01 : 2'b00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [18:0] w);
    @(negedge clk);
    word_i = w;
    #1;
    chk(req, {30'd0, err_rail}, {30'd0, expect_rail(w)});
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    word_i = {ST_OK, GM_OK, GB_OK, GA_OK};
    #2;
    chk("R8", {31'd0, err_flag}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R8", {31'd0, err_flag}, 32'd0);

    for (int i = 0; i < 32; i++) apply("R1", {ST_OK, GM_OK, GB_OK, i[4:0]});
    for (int i = 0; i < 16; i++) apply("R2", {ST_OK, GM_OK, i[3:0], GA_OK});
    for (int i = 0; i < 16; i++) apply("R3", {ST_OK, i[3:0], GB_OK, GA_OK});
    for (int i = 0; i < 64; i++) apply("R4", {i[5:0], GM_OK, GB_OK, GA_OK});
    for (int i = 0; i < 300; i++) begin
      logic [31:0] h;
      h = i * 32'h9E3779B1;
      apply("R5", h[18:0]);
    end
    apply("R5", {6'b111111, 4'b0000, GB_OK, GA_OK});
    apply("R5", {6'b000000, GM_OK, 4'b1111, 5'b00000});
    @(negedge clk);
    chk("R6 no set while disabled", {31'd0, err_flag}, 32'd0);

    @(negedge clk);
    word_i = {ST_OK, GM_OK, GB_OK, 5'b00011};
    chk_en = 1'b1;
    @(negedge clk);
    chk("R6 set", {31'd0, err_flag}, 32'd1);
    word_i = {ST_OK, GM_OK, GB_OK, GA_OK};
    repeat (3) @(negedge clk);
    chk("R7 sticky", {31'd0, err_flag}, 32'd1);
    word_i = {ST_OK, GM_OK, GB_OK, 5'b00000};
    clr = 1'b1;
    @(negedge clk);
    chk("R7 clear priority", {31'd0, err_flag}, 32'd0);
    clr = 1'b0;
    chk_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 disabled", {31'd0, err_flag}, 32'd0);
    chk_en = 1'b1;
    word_i = {ST_OK, GM_OK, GB_OK, GA_OK};
    repeat (2) @(negedge clk);
    chk("R6 valid no set", {31'd0, err_flag}, 32'd0);
    word_i = {6'b000111, 4'b1110, GB_OK, GA_OK};
    @(negedge clk);
    chk("R6 set merged", {31'd0, err_flag}, 32'd1);
    chk_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 reset", {31'd0, err_flag}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule